// File: doc/BRIEF.md
# Fine-Adjusted PWM D/A Generator

This block turns a 14-bit code into a single pulse-width-modulated output whose long-term average follows the code, so a simple external low-pass filter yields an analog level. A 14-bit counter, advanced once per resolution tick, divides each conversion period of 16384 ticks into base cycles. In every base cycle the output is high for a coarse number of ticks taken from the upper code bits. In some base cycles it stays high one tick longer. Those cycles are chosen by comparing the bit-reversed base-cycle index with the low code bits, which spreads the extra ticks evenly through the period.

A carrier-select bit picks between short base cycles (64 ticks, 256 per period, 6-bit coarse and 8-bit fine parts) and long base cycles (256 ticks, 64 per period, 8-bit coarse and 6-bit fine parts). The 16-bit setting register is reached through an 8-bit port. The upper byte is parked in a temporary latch and is committed together with the lower byte, so software never exposes a half-written value. A committed value only becomes active at the next counter wrap. If the active value is outside the legal window for its carrier setting, the output is held low.

Top module: `fapwm_dac`

## Requirements
- R1: After reset the setting register reads 0xFFFF, the output is low, and the counter starts at 0, so the first tick drives the output high.
- R2: The register layout is: code bits 13..0 in bits 15..2, carrier select in bit 1 (0 = 64-tick base cycle, 1 = 256-tick base cycle), and a reserved bit 0 that always reads 1 and ignores writes.
- R3: A write with byte_hi=1 only loads a temporary latch. A write with byte_hi=0 commits {latch, wdata} to the register in one step. A read with byte_hi=1 returns bits 15..8 and captures bits 7..0 for the following byte_hi=0 read.
- R4: The counter and the output change only on cycles with tick_en high. With tick_en low, the output holds its value.
- R5: With carrier select 0, the base position is counter bits 5..0, the base index is counter bits 13..6, the coarse width is code bits 13..8, and the fine value is code bits 7..0.
- R6: With carrier select 1, the base position is counter bits 7..0, the base index is counter bits 13..8, the coarse width is code bits 13..6, and the fine value is code bits 5..0.
- R7: A base cycle with index k is stretched by one tick exactly when bit-reverse(k), taken over the index width, is below the fine value. The number of high ticks in one whole period therefore equals the 14-bit code.
- R8: The active value is legal from 0x0401 to 0xFFFD with carrier select 0, and from 0x0103 to 0xFFFF with carrier select 1. Outside that window the output stays low for the whole period.
- R9: A committed value is copied to the active setting only when the counter wraps from 16383 to 0. The rest of the current period follows the old value.
- R10: The output is registered. After a tick taken with counter value c, the output is high when position(c) < coarse + (stretch ? 1 : 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Resolution tick enable; the counter advances once per high cycle |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (a high-byte read captures the low byte) |
| byte_hi | input | 1 | Byte select for reads and writes: 1 = upper byte, 0 = lower byte |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte |
| pwm_out | output | 1 | Modulated output |

## Verification
On every cycle, the assertions check the following:
- the reserved bit stays at 1;
- the register stays still unless a lower-byte write occurs;
- the counter steps by one per tick and freezes without one;
- the active setting moves only at a wrap;
- the output is low for illegal settings, high at each base-cycle start, and stretched or not at the coarse edge according to the fine selection.

Only the bench's scenarios can show whole-period properties:
- the high-tick count per period equals the code for both carrier settings and at both ends of the legal windows;
- the exact tick-by-tick placement of the stretched cycles;
- a mid-period write leaving the current period untouched.

// File: rtl/fapwm_pkg.sv
package fapwm_pkg;

  localparam int BYTE_W   = 8;
  localparam int REG_W    = 2 * BYTE_W;
  localparam int CODE_W   = 14;
  localparam int CNT_W    = 14;
  localparam int SHORT_W  = 6;                 // position bits, short base cycle
  localparam int LONG_W   = 8;                 // position bits, long base cycle
  localparam int SIDX_W   = CNT_W - SHORT_W;   // index bits, short base cycle
  localparam int LIDX_W   = CNT_W - LONG_W;    // index bits, long base cycle
  localparam int FIELD_W  = 8;                 // widest coarse/fine/pos field

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              long_base;
    logic              rsv;
  } setting_t;

  localparam setting_t RESET_VAL = '1;

  localparam logic [REG_W-1:0] SHORT_MIN = 16'h0401;
  localparam logic [REG_W-1:0] SHORT_MAX = 16'hFFFD;
  localparam logic [REG_W-1:0] LONG_MIN  = 16'h0103;
  localparam logic [REG_W-1:0] LONG_MAX  = 16'hFFFF;

  // Legal-window test on the full 16-bit setting.
  function automatic logic in_window(setting_t s);
    logic [REG_W-1:0] v;
    v = s;
    if (s.long_base) return (v >= LONG_MIN) && (v <= LONG_MAX);
    return (v >= SHORT_MIN) && (v <= SHORT_MAX);
  endfunction

  function automatic logic [FIELD_W-1:0] coarse_of(setting_t s);
    if (s.long_base) return s.code[CODE_W-1 -: LONG_W];
    return FIELD_W'(s.code[CODE_W-1 -: SHORT_W]);
  endfunction

  function automatic logic [FIELD_W-1:0] fine_of(setting_t s);
    if (s.long_base) return FIELD_W'(s.code[LIDX_W-1:0]);
    return FIELD_W'(s.code[SIDX_W-1:0]);
  endfunction

  function automatic logic [FIELD_W-1:0] pos_of(logic [CNT_W-1:0] c, logic long_base);
    if (long_base) return FIELD_W'(c[LONG_W-1:0]);
    return FIELD_W'(c[SHORT_W-1:0]);
  endfunction

  // Base-cycle index with its bit order reversed over the index width.
  function automatic logic [FIELD_W-1:0] rev_index(logic [CNT_W-1:0] c, logic long_base);
    logic [FIELD_W-1:0] r;
    r = '0;
    if (long_base) begin
      for (int b = 0; b < LIDX_W; b++) r[b] = c[CNT_W-1-b];
    end else begin
      for (int b = 0; b < SIDX_W; b++) r[b] = c[CNT_W-1-b];
    end
    return r;
  endfunction

  function automatic logic drive_high(logic [FIELD_W-1:0] pos,
                                      logic [FIELD_W-1:0] coarse,
                                      logic stretch);
    logic [FIELD_W:0] lim;
    lim = {1'b0, coarse} + {{FIELD_W{1'b0}}, stretch};
    return {1'b0, pos} < lim;
  endfunction

endpackage

// File: rtl/fapwm_regs.sv
module fapwm_regs
  import fapwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output setting_t          setting_o
);

  logic [BYTE_W-1:0] wr_hold_q;
  logic [BYTE_W-1:0] rd_hold_q;
  setting_t          setting_q;
  logic              park_hi;
  logic              commit_lo;
  logic              snap_lo;
  logic [REG_W-1:0]  commit_val;

  assign park_hi    = wr_en && byte_hi;
  assign commit_lo  = wr_en && !byte_hi;
  assign snap_lo    = rd_en && byte_hi;
  assign commit_val = {wr_hold_q, wdata} | REG_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_hold_q <= '1;
      rd_hold_q <= '1;
      setting_q <= RESET_VAL;
    end else begin
      if (park_hi)   wr_hold_q <= wdata;
      if (commit_lo) setting_q <= setting_t'(commit_val);
      if (snap_lo)   rd_hold_q <= setting_q[BYTE_W-1:0];
    end
  end

  assign rdata     = byte_hi ? setting_q[REG_W-1:BYTE_W] : rd_hold_q;
  assign setting_o = setting_q;

  p_reserved_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    setting_q.rsv);

  p_commit_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_lo |=> $stable(setting_q));

endmodule

// File: rtl/fapwm_counter.sv
module fapwm_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_en && (&cnt_q);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt_q == $past(cnt_q) + ONE);

  p_count_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));

endmodule

// File: rtl/fapwm_shaper.sv
module fapwm_shaper
  import fapwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  setting_t         setting_i,
  output logic             pwm_o
);

  setting_t             act_q;
  logic                 act_legal;
  logic [FIELD_W-1:0]   coarse;
  logic [FIELD_W-1:0]   fine;
  logic [FIELD_W-1:0]   pos;
  logic [FIELD_W-1:0]   rev;
  logic                 stretch;
  logic                 level;
  logic                 pwm_q;

  // Active setting follows the register only at a period boundary.
  always_ff @(posedge clk) begin
    if (!rst_n)      act_q <= RESET_VAL;
    else if (wrap_i) act_q <= setting_i;
  end

  assign act_legal = in_window(act_q);
  assign coarse    = coarse_of(act_q);
  assign fine      = fine_of(act_q);
  assign pos       = pos_of(cnt_i, act_q.long_base);
  assign rev       = rev_index(cnt_i, act_q.long_base);
  assign stretch   = rev < fine;
  assign level     = drive_high(pos, coarse, stretch);

  always_ff @(posedge clk) begin
    if (!rst_n)       pwm_q <= 1'b0;
    else if (tick_en) pwm_q <= act_legal && level;
  end

  assign pwm_o = pwm_q;

  p_load_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(wrap_i));

  p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !act_legal) |=> !pwm_q);

  p_base_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && act_legal && pos == '0) |=> pwm_q);

  p_out_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(pwm_q));

  p_fine_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && act_legal && pos == coarse && stretch) |=> pwm_q);

  p_no_fine_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && act_legal && pos == coarse && !stretch) |=> !pwm_q);

endmodule

// File: rtl/fapwm_dac.sv
module fapwm_dac
  import fapwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       byte_hi,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       pwm_out
);

  setting_t         setting;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  fapwm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .byte_hi   (byte_hi),
    .wdata     (wdata),
    .rdata     (rdata),
    .setting_o (setting)
  );

  fapwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  fapwm_shaper u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wrap_i    (wrap),
    .cnt_i     (cnt),
    .setting_i (setting),
    .pwm_o     (pwm_out)
  );

endmodule

// File: tb/fapwm_dac_bench.sv
module fapwm_dac_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 16384;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       byte_hi = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pwm_out;

  int          n_checks = 0;
  int          n_fail = 0;
  int          m_cnt = 0;
  logic [15:0] m_act = 16'hFFFF;
  logic [15:0] m_next = 16'hFFFF;
  int          mism = 0;
  int          hi_cnt = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fapwm_dac u_fapwm_dac (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .byte_hi(byte_hi), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected level after a tick taken at counter value c with setting r.
  function automatic bit exp_level(int c, logic [15:0] r);
    int code, base, nbase, nbits, coarse, fine, pos, k, rk;
    bit legal;
    code = int'(r >> 2);
    if (r[1]) begin
      base = 256; nbits = 6; legal = (r >= 16'h0103);
    end else begin
      base = 64;  nbits = 8; legal = (r >= 16'h0401) && (r <= 16'hFFFD);
    end
    nbase  = PERIOD / base;
    coarse = code / nbase;
    fine   = code % nbase;
    pos    = c % base;
    k      = c / base;
    rk     = 0;
    for (int b = 0; b < nbits; b++)
      if (((k >> b) & 1) == 1) rk = rk | (1 << (nbits - 1 - b));
    return legal && (pos < coarse + ((rk < fine) ? 1 : 0));
  endfunction

  task automatic run_ticks(input int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out !== exp_level(m_cnt, m_act)) mism++;
      if (pwm_out) hi_cnt++;
      if (m_cnt == PERIOD - 1) begin
        m_cnt = 0;
        m_act = m_next;
      end else begin
        m_cnt++;
      end
    end
    tick_en = 1'b0;
  endtask

  task automatic wr_byte(input bit hi, input logic [7:0] v);
    wr_en = 1'b1; byte_hi = hi; wdata = v;
    @(negedge clk);
    wr_en = 1'b0; byte_hi = 1'b0;
  endtask

  task automatic wr16(input logic [15:0] v);
    wr_byte(1'b1, v[15:8]);
    wr_byte(1'b0, v[7:0]);
    m_next = v | 16'h0001;
  endtask

  task automatic rd16(output logic [15:0] v);
    rd_en = 1'b1; byte_hi = 1'b1;
    #1 v[15:8] = rdata;
    @(negedge clk);
    rd_en = 1'b0; byte_hi = 1'b0;
    #1 v[7:0] = rdata;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check(pwm_out == 1'b0, "R1", "output after reset", int'(pwm_out), 0);
    rd16(v);
    check(v == 16'hFFFF, "R1", "register after reset", int'(v), 16'hFFFF);
  endtask

  task automatic t_atomic;
    logic [15:0] v;
    wr_byte(1'b1, 8'h12);
    rd16(v);
    check(v == 16'hFFFF, "R3", "upper byte alone must not commit", int'(v), 16'hFFFF);
    wr_byte(1'b0, 8'h34);
    m_next = 16'h1235;
    rd16(v);
    check(v == 16'h1235, "R2", "reserved bit forced to 1 on commit", int'(v), 16'h1235);
    check(pwm_out == 1'b0, "R4", "no tick, output unchanged", int'(pwm_out), 0);
  endtask

  // First period: reset value active, includes a stretch with tick_en low.
  task automatic t_first_period;
    logic held;
    bit   moved;
    mism = 0; hi_cnt = 0;
    run_ticks(10);
    check(pwm_out == 1'b1, "R10", "output high early in base cycle", int'(pwm_out), 1);
    held = pwm_out; moved = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (pwm_out !== held) moved = 1'b1;
    end
    check(!moved, "R4", "output held while tick_en low", int'(moved), 0);
    run_ticks(PERIOD - 10);
    check(mism == 0, "R6", "long-base tick pattern mismatches", mism, 0);
    check(hi_cnt == 16'h3FFF, "R7", "high ticks, long base, full code", hi_cnt, 16'h3FFF);
  endtask

  // One whole period with a new value committed midway (R9 deferral).
  task automatic t_period(input string req, input int exp_hi, input logic [15:0] nxt);
    mism = 0; hi_cnt = 0;
    run_ticks(6000);
    wr16(nxt);
    run_ticks(PERIOD - 6000);
    check(mism == 0, "R9", {req, " tick pattern with mid-period write"}, mism, 0);
    check(hi_cnt == exp_hi, req, "high ticks per period", hi_cnt, exp_hi);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_atomic();
    t_first_period();
    t_period("R5", 16'h048D, 16'h00FD);
    rd16(v);
    check(v == 16'h00FD, "R9", "register holds pending value", int'(v), 16'h00FD);
    t_period("R8", 0, 16'h0103);
    t_period("R6", 16'h0040, 16'h00FF);
    t_period("R8", 0, 16'h0401);
    t_period("R8", 16'h0100, 16'hFFFD);
    t_period("R7", 16'h3FFF, 16'h0401);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule